// File: doc/BRIEF.md
# Parallel I/O Port With Pin Interrupts

This block is a general-purpose parallel I/O port of up to 32 pins, managed by a host through a small word-addressed register bus. Each pin can be turned into an output that drives a software-written level, or left as an input whose level software can read. The pad itself is not part of the block: it is presented as three separate vectors for the incoming level, the outgoing level and the drive enable.

Input levels pass through a two-stage synchroniser. From there they feed either an edge detector that latches events into a sticky per-pin capture register, or a direct level comparison. Which of these is used, and which edge counts, is chosen by a build-time parameter: rising, falling, both edges or level-high. Software cannot change it. One registered interrupt line goes to the host. Software acknowledges edge events by writing ones to the capture word.

Top module: `pio_irq_ctrl`

## Requirements
- R1: The register select `reg_sel` picks a word: 0 is pin data (byte offset 0x0), 1 is direction (0x4), 2 is interrupt enable (0x8) and 3 is the event capture word (0xC). `rdata` is registered and shows the word selected at a clock edge right after that edge.
- R2: A direction bit of 1 makes its pin an output, so `pin_oe` is 1 there. Writing word 0 loads the output latch. `pin_out` carries the latch value only on pins whose direction bit is 1 and is 0 on input pins. Both outputs follow a write from the edge that takes it.
- R3: Reading word 0 returns the pin inputs after two synchronising flops and does not return the output latch. A pin change driven before edge E1 is in `rdata` from edge E3.
- R4: In the rising, falling and both-edges builds, a capture bit is set when its synchronised input goes 0 to 1, 1 to 0, or either way, respectively. This happens whatever the interrupt-enable bit is. The bit is set at the edge after the synchronised level changes, which is E3 for a change before E1. In the level-high build the capture word reads as zero.
- R5: A write to word 3 clears each capture bit that is 1 in the written word and leaves capture bits written as 0 unchanged.
- R6: When a capture bit's edge and a clearing write take effect at the same clock edge, the bit ends up set.
- R7: In edge builds, `irq` is 1 exactly when capture AND enable is nonzero, registered one edge after that term changes. It is 0 while the enable word is zero.
- R8: In the level-high build, `irq` is 1 exactly when synchronised input AND enable is nonzero, registered one edge after the synchronised level. A pin change before E1 reaches `irq` at E3.
- R9: Bits at or above `NUM_PINS` read as zero in every word, and writes to them are ignored.
- R10: Reset clears the direction, enable, capture and output latches, `irq` and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 2 | Word select (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data of the selected word |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output level, gated to output pins |
| pin_oe | output | NUM_PINS | Drive enable per pin |
| irq | output | 1 | Interrupt to host, registered |

## Verification
Each result has a fixed due edge. Counting from a pin change driven before edge E1: read data is due at E3, a capture bit at E3, a level interrupt at E3 and an edge interrupt at E4. A register write reaches `pin_out` and `pin_oe` at the edge that takes it, and a read returns one edge after the select. The bench drives every stimulus just after a falling clock edge and counts falling edges to the due edge. It checks the edge before as well as the due edge, so a result that arrives one cycle early or late is reported. Four builds, one per trigger type, share the stimulus, and every ordered pair of 4-pin input patterns is swept through them.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int unsigned BUS_W = 32;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_EN   = 2'd2;
  localparam logic [1:0] SEL_CAP  = 2'd3;
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/pio_edge_cap.sv
module pio_edge_cap
  import pio_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter trig_e       TRIGGER = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_sync,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] cap
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cap_q;
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_only;

  // Event selection fixed at build time; the level build never latches.
  always_comb begin
    case (TRIGGER)
      TRIG_RISE: set_vec = lvl_sync & ~prev_q;
      TRIG_FALL: set_vec = ~lvl_sync & prev_q;
      TRIG_BOTH: set_vec = lvl_sync ^ prev_q;
      default:   set_vec = '0;
    endcase
  end

  assign clr_only = clr_vec & ~set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cap_q  <= '0;
    end else begin
      prev_q <= lvl_sync;
      // set after clear: a same-cycle event survives the acknowledge
      cap_q  <= (cap_q & ~clr_vec) | set_vec;
    end
  end

  assign cap = cap_q;

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cap_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_only != '0) |=> ((cap_q & $past(clr_only)) == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec == '0) && (set_vec == '0)) |=> $stable(cap_q));
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter trig_e       TRIGGER  = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          reg_sel,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int unsigned W = NUM_PINS;

  logic [W-1:0]     lvl_sync;
  logic [W-1:0]     cap;
  logic [W-1:0]     clr_vec;
  logic [W-1:0]     dir_q;
  logic [W-1:0]     en_q;
  logic [W-1:0]     out_q;
  logic [W-1:0]     rd_sel;
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] rdata_q;
  logic             irq_q;
  logic             irq_term;

  pio_sync2 #(.W(W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (lvl_sync)
  );

  assign clr_vec = (wr_en && reg_sel == SEL_CAP) ? wdata[W-1:0] : '0;

  pio_edge_cap #(.W(W), .TRIGGER(TRIGGER)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .lvl_sync (lvl_sync),
    .clr_vec  (clr_vec),
    .cap      (cap)
  );

  // Control latches; only the low W bits of a write are kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      en_q  <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_DATA: out_q <= wdata[W-1:0];
        SEL_DIR:  dir_q <= wdata[W-1:0];
        SEL_EN:   en_q  <= wdata[W-1:0];
        default:  ;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

  // Read path: select, zero-extend, register.
  always_comb begin
    case (reg_sel)
      SEL_DATA: rd_sel = lvl_sync;
      SEL_DIR:  rd_sel = dir_q;
      SEL_EN:   rd_sel = en_q;
      default:  rd_sel = cap;
    endcase
    rd_word         = '0;
    rd_word[W-1:0]  = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign rdata = rdata_q;

  // Interrupt source picked by the build-time trigger.
  if (TRIGGER == TRIG_LEVEL) begin : g_level_irq
    assign irq_term = |(lvl_sync & en_q);

    assert_level_irq_R8: assert property (@(posedge clk) disable iff (rst)
      ((lvl_sync & en_q) != '0) |=> irq);
  end else begin : g_edge_irq
    assign irq_term = |(cap & en_q);

    assert_edge_irq_R7: assert property (@(posedge clk) disable iff (rst)
      ((cap & en_q) != '0) |=> irq);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_term;
  end

  assign irq = irq_q;

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);

  assert_oe_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == SEL_DIR) |=> (pin_oe == $past(wdata[W-1:0])));

  if (W < BUS_W) begin : g_upper_zero
    always @(posedge clk) begin
      if (!rst) begin
        assert_upper_zero_R9: assert (rdata[BUS_W-1:W] == '0);
      end
    end
  end
endmodule

// File: tb/pio_irq_ctrl_tb.sv
module pio_irq_ctrl_tb;
  import pio_pkg::*;

  localparam int unsigned NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] pin_in = '0;

  logic [31:0]   rd_rise, rd_fall, rd_both, rd_lvl;
  logic [NP-1:0] po_rise, po_fall, po_both, po_lvl;
  logic [NP-1:0] oe_rise, oe_fall, oe_both, oe_lvl;
  logic          irq_rise, irq_fall, irq_both, irq_lvl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pio_irq_ctrl #(.NUM_PINS(NP), .TRIGGER(TRIG_RISE)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_rise), .pin_in(pin_in), .pin_out(po_rise), .pin_oe(oe_rise), .irq(irq_rise));
  pio_irq_ctrl #(.NUM_PINS(NP), .TRIGGER(TRIG_FALL)) u_dut_fall (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_fall), .pin_in(pin_in), .pin_out(po_fall), .pin_oe(oe_fall), .irq(irq_fall));
  pio_irq_ctrl #(.NUM_PINS(NP), .TRIGGER(TRIG_BOTH)) u_dut_both (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_both), .pin_in(pin_in), .pin_out(po_both), .pin_oe(oe_both), .irq(irq_both));
  pio_irq_ctrl #(.NUM_PINS(NP), .TRIGGER(TRIG_LEVEL)) u_dut_lvl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rd_lvl), .pin_in(pin_in), .pin_out(po_lvl), .pin_oe(oe_lvl), .irq(irq_lvl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wdata = val;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
  endtask

  function automatic logic [31:0] z(input logic [NP-1:0] v);
    return {{(32-NP){1'b0}}, v};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    nedge(3);
    rst = 1'b0;

    // R10: reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s));
      chk("R10 reset word rise", rd_rise, 32'd0);
      chk("R10 reset word level", rd_lvl, 32'd0);
    end
    chk("R10 reset pin_oe", z(oe_rise), 32'd0);
    chk("R10 reset pin_out", z(po_rise), 32'd0);
    chk("R10 reset irq", {31'd0, irq_rise | irq_lvl}, 32'd0);

    // R9 / R1: unused bits, word map
    wr(SEL_EN, 32'hFFFF_FFFF);
    rd(SEL_EN);
    chk("R9 enable upper bits", rd_rise, 32'h0000_000F);
    wr(SEL_EN, 32'h0);
    wr(SEL_DIR, 32'hA5A5_A5A6);
    rd(SEL_DIR);
    chk("R1 direction word", rd_rise, 32'h0000_0006);
    rd(SEL_EN);
    chk("R1 enable word independent", rd_rise, 32'h0);

    // R2: direction gates output drive, visible right after the write edge
    wr(SEL_DIR, 32'h5);
    chk("R2 pin_oe", z(oe_rise), 32'h5);
    wr(SEL_DATA, 32'hA);
    chk("R2 pin_out input pins silent", z(po_rise), 32'h0);
    wr(SEL_DATA, 32'hF);
    chk("R2 pin_out output pins", z(po_both), 32'h5);
    wr(SEL_DIR, 32'h0);
    chk("R2 pin_out after dir clear", z(po_rise), 32'h0);

    // R3: data read is synchronised input, due at E3
    rd(SEL_DATA);
    pin_in = 4'h3;
    nedge(2);
    chk("R3 data before E3", rd_rise, 32'h0);
    nedge(1);
    chk("R3 data at E3", rd_rise, 32'h3);
    pin_in = 4'h0;
    nedge(4);
    wr(SEL_CAP, 32'hFFFF_FFFF);

    // R4 / R7: sweep every ordered pair of patterns, enables off
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        logic [NP-1:0] ov, nv;
        ov = 4'(o);
        nv = 4'(n);
        @(negedge clk);
        pin_in = ov;
        nedge(4);
        wr(SEL_CAP, 32'hF);
        pin_in = nv;
        nedge(4);
        rd(SEL_CAP);
        chk("R4 rising capture", rd_rise, z(nv & ~ov));
        chk("R4 falling capture", rd_fall, z(~nv & ov));
        chk("R4 both capture", rd_both, z(nv ^ ov));
        chk("R4 level capture zero", rd_lvl, 32'h0);
        chk("R7 disabled irq quiet", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 32'h0);
      end
    end

    // R5: partial clear
    @(negedge clk);
    pin_in = 4'h0;
    nedge(4);
    wr(SEL_CAP, 32'hF);
    pin_in = 4'hF;
    nedge(4);
    wr(SEL_CAP, 32'h5);
    rd(SEL_CAP);
    chk("R5 partial clear", rd_rise, 32'hA);

    // R6: clear and edge on the same edge
    @(negedge clk);
    pin_in = 4'h0;
    nedge(4);
    wr(SEL_CAP, 32'hF);
    pin_in = 4'h2;
    nedge(4);
    @(negedge clk);
    pin_in = 4'h3;
    nedge(2);
    wr_en = 1'b1; reg_sel = SEL_CAP; wdata = 32'h3;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(SEL_CAP);
    chk("R6 set wins over clear", rd_rise, 32'h1);

    // R7 / R8: interrupt timing
    @(negedge clk);
    pin_in = 4'h0;
    nedge(4);
    wr(SEL_CAP, 32'hF);
    wr(SEL_EN, 32'h4);
    nedge(2);
    chk("R7 idle irq", {31'd0, irq_rise}, 32'd0);
    pin_in = 4'h4;
    nedge(2);
    chk("R8 level irq before E3", {31'd0, irq_lvl}, 32'd0);
    nedge(1);
    chk("R8 level irq at E3", {31'd0, irq_lvl}, 32'd1);
    chk("R7 edge irq before E4", {31'd0, irq_rise}, 32'd0);
    nedge(1);
    chk("R7 edge irq at E4", {31'd0, irq_rise}, 32'd1);
    chk("R7 falling build quiet on rise", {31'd0, irq_fall}, 32'd0);
    wr(SEL_CAP, 32'h4);
    nedge(1);
    chk("R7 irq drops after clear", {31'd0, irq_rise}, 32'd0);
    pin_in = 4'h5;
    nedge(5);
    chk("R7 disabled pin no irq", {31'd0, irq_rise}, 32'd0);
    rd(SEL_CAP);
    chk("R4 capture despite disable", rd_rise, 32'h1);
    pin_in = 4'h1;
    nedge(3);
    chk("R8 level irq drops", {31'd0, irq_lvl}, 32'd0);
    chk("R7 falling build irq", {31'd0, irq_fall}, 32'd0);
    nedge(1);
    chk("R7 falling build irq at E4", {31'd0, irq_fall}, 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule